// File: doc/BRIEF.md
# Packed Default Attribute Loader

This block fills a small table of default vertex attributes from a stream of 32-bit register writes. Each table entry is a vector of four 24-bit floating-point values (x, y, z, w). The 96 bits of a vector are spread over three data words. A register write that lands in the block's three-address data window is appended to a staging buffer, whichever of the three addresses it used. The arrival of the third word completes the vector. The block then splits the 96 bits into the four components, placing them in reverse order, and writes the vector into the table entry chosen by a target-index register.

After each good commit the target index steps forward by one, so software can load a run of consecutive entries by streaming words without rewriting the index. A commit aimed at an index past the end of the table stores nothing and raises a sticky error flag. Writing the index register sets a new target, clears the flag and realigns the staging buffer. A synchronous read port returns any stored vector one cycle after it is requested. The 24-bit values pass through untouched; no format conversion is done.

Top module: `attr_loader`

## Requirements
- R1: A data write is accepted only when `reg_wr_en` is high and `reg_addr` is 0x233, 0x234 or 0x235. Writes to any other address leave the staging buffer, the table and the flag unchanged.
- R2: Accepted words are staged in arrival order, whatever their address within the window. The third accepted word commits the vector and the staging count returns to zero, so the next word starts a new vector.
- R3: With staged words A (first), B and C (third), the components are w = A[31:8], z = {A[7:0], B[31:16]}, y = {B[15:0], C[31:24]} and x = C[23:0]. The stored vector reads back as `rd_data` = {x, y, z, w}, with x in bits [95:72] and w in bits [23:0].
- R4: A commit with target index below 16 writes the table entry at that index, and the index then advances by one.
- R5: A commit with target index 16 or above changes no table entry, leaves the index unchanged and sets `attr_err`.
- R6: Once set, `attr_err` stays high until the next index-register write or reset.
- R7: An index-register write loads `idx_wdata` as the target, clears `attr_err` and clears the staging count. A data write in the same cycle is discarded.
- R8: When `rd_en` is high, the entry at `rd_addr` appears on `rd_data` after the next clock edge. When `rd_en` is low, `rd_data` holds its value.
- R9: A read of the entry that a commit writes in the same cycle returns the contents from before the commit.
- R10: After reset the staging count is zero, the target index is zero, `attr_err` is low and every table entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register write address |
| reg_wdata | input | 32 | Register write data |
| idx_wr_en | input | 1 | Target-index register write strobe |
| idx_wdata | input | 5 | New target index |
| rd_en | input | 1 | Table read request |
| rd_addr | input | 4 | Table entry to read |
| rd_data | output | 96 | Read vector {x, y, z, w} |
| attr_err | output | 1 | Sticky out-of-range commit flag |

## Verification
Misalignment in the staging count is the most likely fault. It does not show up on the next read. It first appears when the following vector commits: that vector's fields come back rotated by one word, or it lands in the entry after the intended one. A wrong target index shows as a correct vector sitting in the wrong entry, and as an error flag that rises one commit too early or too late. For these reasons the bench reads entries back after every committed vector and checks the flag on every cycle, so a bad state is caught within a vector of its cause.

// File: rtl/attr_pkg.sv
package attr_pkg;
    localparam int WORD_W        = 32;
    localparam int COMP_W        = 24;
    localparam int WORDS_PER_VEC = 3;
    localparam int VEC_W         = 4 * COMP_W;
    localparam int CNT_W         = $clog2(WORDS_PER_VEC);

    // x occupies the most significant bits
    typedef struct packed {
        logic [COMP_W-1:0] x;
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] z;
        logic [COMP_W-1:0] w;
    } vec4_t;
endpackage

// File: rtl/attr_stage.sv
module attr_stage
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    input  logic              realign,
    output logic              commit,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic [WORD_W-1:0] word2,
    output logic [CNT_W-1:0]  fill
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORDS_PER_VEC - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] first;
        logic [WORD_W-1:0] second;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        commit  = 1'b0;
        if (realign) begin
            stage_d.cnt = '0;
        end else if (word_vld) begin
            if (stage_q.cnt == LAST_SLOT) begin
                commit      = 1'b1;
                stage_d.cnt = '0;
            end else begin
                if (stage_q.cnt == '0) begin
                    stage_d.first = word;
                end else begin
                    stage_d.second = word;
                end
                stage_d.cnt = stage_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign word0 = stage_q.first;
    assign word1 = stage_q.second;
    assign word2 = word;
    assign fill  = stage_q.cnt;
endmodule

// File: rtl/attr_unpack.sv
module attr_unpack
    import attr_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  logic [WORD_W-1:0] word2,
    output vec4_t             vec
);
    localparam int SPLIT_A = WORD_W - COMP_W;
    localparam int SPLIT_B = 2 * SPLIT_A;

    always_comb begin
        vec.w = word0[WORD_W-1:SPLIT_A];
        vec.z = {word0[SPLIT_A-1:0], word1[WORD_W-1:WORD_W-(COMP_W-SPLIT_A)]};
        vec.y = {word1[SPLIT_B-1:0], word2[WORD_W-1:COMP_W]};
        vec.x = word2[COMP_W-1:0];
    end
endmodule

// File: rtl/attr_index.sv
module attr_index #(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_val,
    input  logic             commit,
    output logic [IDX_W-1:0] idx,
    output logic             wr_ok,
    output logic             err
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             err;
    } index_t;

    index_t idx_d, idx_q;
    logic   in_range;

    always_comb begin
        idx_d    = idx_q;
        in_range = idx_q.idx < IDX_W'(NUM_ENTRIES);
        wr_ok    = commit && in_range && !idx_wr;
        if (idx_wr) begin
            idx_d.idx = idx_val;
            idx_d.err = 1'b0;
        end else if (commit) begin
            if (in_range) begin
                idx_d.idx = idx_q.idx + 1'b1;
            end else begin
                idx_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx = idx_q.idx;
    assign err = idx_q.err;
endmodule

// File: rtl/attr_mem.sv
module attr_mem
    import attr_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int RA_W        = $clog2(NUM_ENTRIES),
    parameter int IDX_W       = RA_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  vec4_t            wr_data,
    input  logic             rd_en,
    input  logic [RA_W-1:0]  rd_addr,
    output vec4_t            rd_data
);
    typedef struct packed {
        vec4_t [NUM_ENTRIES-1:0] ent;
        vec4_t                   rd;
    } mem_t;

    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (rd_en) begin
            mem_d.rd = mem_q.ent[rd_addr];
        end
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (wr_en && (wr_addr == IDX_W'(e))) begin
                mem_d.ent[e] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q.rd;
endmodule

// File: rtl/attr_loader.sv
module attr_loader
    import attr_pkg::*;
#(
    parameter int              NUM_ENTRIES = 16,
    parameter int              ADDR_W      = 12,
    parameter logic [11:0]     BASE_ADDR   = 12'h233,
    localparam int             RA_W        = $clog2(NUM_ENTRIES),
    localparam int             IDX_W       = RA_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    input  logic               idx_wr_en,
    input  logic [IDX_W-1:0]   idx_wdata,
    input  logic               rd_en,
    input  logic [RA_W-1:0]    rd_addr,
    output logic [VEC_W-1:0]   rd_data,
    output logic               attr_err
);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(BASE_ADDR + WORDS_PER_VEC - 1);

    logic              word_hit;
    logic              stage_commit;
    logic [WORD_W-1:0] w0, w1, w2;
    logic [CNT_W-1:0]  stage_fill;
    vec4_t             unpacked;
    logic [IDX_W-1:0]  cur_idx;
    logic              mem_we;
    vec4_t             rd_vec;

    assign word_hit = reg_wr_en && (reg_addr >= WIN_LO) && (reg_addr <= WIN_HI);

    attr_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_hit),
        .word     (reg_wdata),
        .realign  (idx_wr_en),
        .commit   (stage_commit),
        .word0    (w0),
        .word1    (w1),
        .word2    (w2),
        .fill     (stage_fill)
    );

    attr_unpack u_unpack (
        .word0 (w0),
        .word1 (w1),
        .word2 (w2),
        .vec   (unpacked)
    );

    attr_index #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr_en),
        .idx_val (idx_wdata),
        .commit  (stage_commit),
        .idx     (cur_idx),
        .wr_ok   (mem_we),
        .err     (attr_err)
    );

    attr_mem #(.NUM_ENTRIES(NUM_ENTRIES), .RA_W(RA_W), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_addr (cur_idx),
        .wr_data (unpacked),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_vec)
    );

    assign rd_data = rd_vec;
endmodule

// File: rtl/attr_loader_chk.sv
module attr_loader_chk #(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 5,
    parameter int CNT_W       = 2,
    parameter int VEC_W       = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idx_wr_en,
    input logic             rd_en,
    input logic [VEC_W-1:0] rd_data,
    input logic             attr_err,
    input logic [CNT_W-1:0] fill,
    input logic             commit,
    input logic [IDX_W-1:0] idx,
    input logic             wr_ok
);
    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(2));

    // R7
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr_en |=> (fill == '0) && !attr_err);

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (idx == IDX_W'($past(idx) + 1'b1)));

    // R5
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !idx_wr_en && (idx >= IDX_W'(NUM_ENTRIES))) |=> (attr_err && $stable(idx)));

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_err && !idx_wr_en) |=> attr_err);

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(attr_err) |-> $past(commit));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind attr_loader attr_loader_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W),
    .CNT_W       (attr_pkg::CNT_W),
    .VEC_W       (attr_pkg::VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr_en (idx_wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .attr_err  (attr_err),
    .fill      (stage_fill),
    .commit    (stage_commit),
    .idx       (cur_idx),
    .wr_ok     (mem_we)
);

// File: tb/test_attr_loader.sv
module test_attr_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        idx_wr_en = 1'b0;
    logic [4:0]  idx_wdata = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [95:0] rd_data;
    logic        attr_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [95:0] exp_mem [16];
    logic [95:0] exp_rd;
    logic [31:0] m_buf [2];
    int          m_cnt;
    int          m_idx;
    bit          m_err;

    always #4 clk = ~clk;

    attr_loader i_attr_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .idx_wr_en (idx_wr_en),
        .idx_wdata (idx_wdata),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .attr_err  (attr_err)
    );

    function automatic logic [95:0] pack_vec(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] c);
        logic [23:0] x, y, z, w;
        w = a[31:8];
        z = {a[7:0], b[31:16]};
        y = {b[15:0], c[31:24]};
        x = c[23:0];
        return {x, y, z, w};
    endfunction

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d,
                        input bit iw, input logic [4:0] iv, input bit re, input logic [3:0] ra);
        @(negedge clk);
        reg_wr_en = we; reg_addr = a; reg_wdata = d;
        idx_wr_en = iw; idx_wdata = iv;
        rd_en = re; rd_addr = ra;
        @(posedge clk);
        // model: read sees pre-edge contents (R9)
        if (re) exp_rd = exp_mem[ra];
        if (iw) begin
            m_idx = int'(iv); m_cnt = 0; m_err = 1'b0;
        end else if (we && a >= 12'h233 && a <= 12'h235) begin
            if (m_cnt == 2) begin
                if (m_idx < 16) begin
                    exp_mem[m_idx] = pack_vec(m_buf[0], m_buf[1], d);
                    m_idx++;
                end else begin
                    m_err = 1'b1;
                end
                m_cnt = 0;
            end else begin
                m_buf[m_cnt] = d;
                m_cnt++;
            end
        end
        #1;
        check("R6 err", {95'd0, attr_err}, {95'd0, m_err});
        if (re) check("R8 read", rd_data, exp_rd);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 5'd0, 1'b0, 4'd0);
    endtask

    task automatic set_idx(input logic [4:0] v);
        step(1'b0, 12'h0, 32'h0, 1'b1, v, 1'b0, 4'd0);
    endtask

    task automatic rd(input logic [3:0] ra);
        step(1'b0, 12'h0, 32'h0, 1'b0, 5'd0, 1'b1, ra);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [95:0] snap;
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        exp_rd = '0; m_cnt = 0; m_idx = 0; m_err = 1'b0;
        m_buf[0] = '0; m_buf[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10 reset state
        #1 check("R10 err after reset", {95'd0, attr_err}, 96'd0);
        for (int i = 0; i < 16; i++) rd(4'(i));

        // R3 field placement, literal expectation
        wr(12'h233, 32'h11223344); wr(12'h233, 32'h55667788); wr(12'h233, 32'h99AABBCC);
        rd(4'd0);
        check("R3 unpack", rd_data, 96'hAABBCC_778899_445566_112233);

        // R2 R4 mixed addresses, auto index 1
        wr(12'h235, 32'hDEADBEEF); wr(12'h233, 32'h01234567); wr(12'h234, 32'h89ABCDEF);
        rd(4'd1);
        check("R4 entry1", rd_data, pack_vec(32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF));

        // R1 outside window ignored
        wr(12'h234, 32'hA0A0A0A0); wr(12'h232, 32'hFFFFFFFF); wr(12'h236, 32'hEEEEEEEE);
        wr(12'h235, 32'hB1B1B1B1); wr(12'h433, 32'h12121212); wr(12'h233, 32'hC2C2C2C2);
        rd(4'd2);
        check("R1 entry2", rd_data, pack_vec(32'hA0A0A0A0, 32'hB1B1B1B1, 32'hC2C2C2C2));

        // R7 realign with same-cycle data dropped
        wr(12'h233, 32'h0BADF00D);
        step(1'b1, 12'h234, 32'h77777777, 1'b1, 5'd5, 1'b0, 4'd0);
        wr(12'h233, 32'h10203040); wr(12'h234, 32'h50607080); wr(12'h235, 32'h90A0B0C0);
        rd(4'd5);
        check("R7 entry5", rd_data, pack_vec(32'h10203040, 32'h50607080, 32'h90A0B0C0));
        rd(4'd3);
        check("R7 entry3 untouched", rd_data, 96'd0);

        // R5 R6 out-of-range
        set_idx(5'd15);
        wr(12'h233, 32'h1); wr(12'h233, 32'h2); wr(12'h233, 32'h3);
        rd(4'd15);
        check("R4 entry15", rd_data, pack_vec(32'h1, 32'h2, 32'h3));
        snap = rd_data;
        wr(12'h233, 32'h4); wr(12'h233, 32'h5); wr(12'h233, 32'h6);
        check("R5 err set", {95'd0, attr_err}, 96'd1);
        rd(4'd15);
        check("R5 entry15 unchanged", rd_data, snap);
        rd(4'd0);
        check("R5 entry0 unchanged", rd_data, 96'hAABBCC_778899_445566_112233);
        wr(12'h233, 32'h7); rd(4'd4);
        check("R6 err holds", {95'd0, attr_err}, 96'd1);
        set_idx(5'd3);
        check("R6 err cleared", {95'd0, attr_err}, 96'd0);

        // R9 same-cycle read returns old contents
        wr(12'h233, 32'hCAFEBABE); wr(12'h234, 32'hFACEFEED);
        step(1'b1, 12'h235, 32'h5A5A5A5A, 1'b0, 5'd0, 1'b1, 4'd3);
        check("R9 old data", rd_data, 96'd0);
        rd(4'd3);
        check("R9 new data", rd_data, pack_vec(32'hCAFEBABE, 32'hFACEFEED, 32'h5A5A5A5A));

        // R8 hold: no request keeps value
        wr(12'h230, 32'h0);
        check("R8 hold", rd_data, pack_vec(32'hCAFEBABE, 32'hFACEFEED, 32'h5A5A5A5A));

        // random traffic, checked by the model each step (R1 R2 R4 R5 R7 R8)
        for (int n = 0; n < 4000; n++) begin
            int unsigned sel;
            sel = $urandom_range(0, 99);
            step(sel < 70, 12'h231 + 12'($urandom_range(0, 6)), $urandom,
                 sel >= 95, 5'($urandom_range(0, 18)),
                 $urandom_range(0, 2) == 0, 4'($urandom_range(0, 15)));
        end
        for (int i = 0; i < 16; i++) rd(4'(i));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule